// File: doc/BRIEF.md
# Priority memory chip-select decoder

This block turns a microcontroller address into the chip selects of a small memory subsystem. It drives four read-only code banks, one scratch RAM, an internal I/O window and a peripheral I/O window. Every window's base and size comes from a parameter, so the same block serves any memory map that keeps to the placement rules. Code banks may sit under the RAM or an I/O window. Wherever they do, the data side wins and the covered code locations cannot be reached.

Addresses count bus locations. In 8-bit bus mode one location is a byte. In 16-bit mode one location is a 16-bit word, so every byte-sized window covers half as many locations. A configuration checker raises an error output when the map breaks a placement rule. The peripheral window takes part in decoding, and in that check, only while its mode enable is high. All outputs are registered, so a select appears one clock after the address that causes it.

Top module: `memsel_decoder`

## Requirements
- R1: Each of the four code banks k (k = 0..3) has a window of BANK_SPAN locations starting at BANK_BASE[k]. An address inside exactly that window, with no data or I/O hit, raises bank_sel[k] (bit k of bank_sel).
- R2: A bank holds BANK_KB x 1024 locations in 8-bit mode (WIDE_BUS = 0) and half that in 16-bit mode (WIDE_BUS = 1), with BANK_KB one of 8, 16 or 32. The four banks together therefore give 32K/64K/128K x 8 or 16K/32K/64K x 16.
- R3: The RAM window starts at RAM_BASE and spans 2048 locations in 8-bit mode and 1024 in 16-bit mode. An address inside it raises ram_sel.
- R4: A hit in the RAM, internal I/O or peripheral I/O window suppresses every bank select for that address.
- R5: The peripheral I/O window raises pio_sel only while pio_en is high. With pio_en low, an address in that window selects what would be selected without it.
- R6: With addr_strobe low, every select output is low on the following cycle.
- R7: At most one of the seven selects is high. The fixed priority is RAM, then internal I/O, then peripheral I/O, then bank 0 up to bank 3 (lowest index first).
- R8: cfg_err is high whenever two bank windows overlap or BANK_SPAN exceeds the bank size of R2.
- R9: cfg_err is high whenever the RAM and internal I/O windows overlap, and also, while pio_en is high, whenever the peripheral window overlaps either of them.
- R10: Selects and cfg_err update on the rising clock edge one cycle after their inputs. A synchronous reset forces them all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | Address valid; selects stay low while it is low |
| addr | input | ADDR_W | Location address from the microcontroller |
| pio_en | input | 1 | Enables the peripheral I/O window |
| bank_sel | output | 4 | One-hot code bank selects |
| ram_sel | output | 1 | Scratch RAM select |
| io_sel | output | 1 | Internal I/O window select |
| pio_sel | output | 1 | Peripheral I/O window select |
| cfg_err | output | 1 | Memory map breaks a placement rule |

## Verification
The assertions assume that addr, addr_strobe and pio_en are synchronous to clk, and that reset is held high from time zero through the first edges. The hold and steady checks also assume that each output depends only on the inputs sampled one edge earlier. The bench therefore changes every input on the falling edge, holds it across the following rising edge, and starts with reset asserted. Its random addresses cover the whole address space of the widest instance. A second instance is fed the low address bits, so every vector stays a legal address for each configuration.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

   localparam int NUM_BANKS = 4;

   // widened range type so base + span never wraps
   typedef logic [32:0] span_t;

   typedef struct packed {
      logic                 pio;
      logic                 io;
      logic                 ram;
      logic [NUM_BANKS-1:0] bank;
   } sel_t;

   function automatic logic ranges_meet(input span_t base_a, input span_t len_a,
                                        input span_t base_b, input span_t len_b);
      if (len_a == '0 || len_b == '0) return 1'b0;
      return (base_a < base_b + len_b) && (base_b < base_a + len_a);
   endfunction

endpackage

// File: rtl/memsel_window.sv
module memsel_window
   import memsel_pkg::*;
#(
   parameter int          ADDR_W = 17,
   parameter int unsigned BASE   = 0,
   parameter int unsigned SPAN   = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam span_t LO = span_t'(BASE);
   localparam span_t HI = span_t'(BASE) + span_t'(SPAN);

   generate
      if (SPAN == 0) begin : g_empty
         assign hit = 1'b0;
      end else if (BASE == 0) begin : g_from_zero
         span_t a_w;
         assign a_w = span_t'(addr);
         assign hit = (a_w < HI);
      end else begin : g_range
         span_t a_w;
         assign a_w = span_t'(addr);
         assign hit = (a_w >= LO) && (a_w < HI);
      end
   endgenerate

endmodule

// File: rtl/memsel_prio.sv
module memsel_prio
   import memsel_pkg::*;
(
   input  logic strobe,
   input  sel_t hits,
   output sel_t win
);

   logic                 data_hit;
   logic [NUM_BANKS:0]   taken;
   logic [NUM_BANKS-1:0] bank_win;

   assign data_hit = hits.ram | hits.io | hits.pio;
   assign taken[0] = 1'b0;

   // lowest bank index wins among code banks
   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_chain
         assign bank_win[k]  = hits.bank[k] & ~taken[k];
         assign taken[k + 1] = taken[k] | hits.bank[k];
      end
   endgenerate

   always_comb begin
      win = '0;
      if (strobe) begin
         if (hits.ram)       win.ram  = 1'b1;
         else if (hits.io)   win.io   = 1'b1;
         else if (hits.pio)  win.pio  = 1'b1;
         else if (!data_hit) win.bank = bank_win;
      end
   end

endmodule

// File: rtl/memsel_cfgchk.sv
module memsel_cfgchk
   import memsel_pkg::*;
#(
   parameter logic [NUM_BANKS-1:0][31:0] BANK_BASE = '0,
   parameter int unsigned BANK_SPAN = 1,
   parameter int unsigned BANK_LOCS = 1,
   parameter int unsigned RAM_BASE  = 0,
   parameter int unsigned RAM_LOCS  = 1,
   parameter int unsigned IO_BASE   = 0,
   parameter int unsigned IO_SPAN   = 1,
   parameter int unsigned PIO_BASE  = 0,
   parameter int unsigned PIO_SPAN  = 1
) (
   input  logic pio_en,
   output logic cfg_fault
);

   localparam int  NPAIR    = NUM_BANKS * NUM_BANKS;
   localparam logic SPAN_BAD = (BANK_SPAN > BANK_LOCS);

   logic [NPAIR-1:0] pair_clash;
   logic             data_clash;
   logic             pio_clash;

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_row
         for (genvar j = 0; j < NUM_BANKS; j++) begin : g_col
            if (j > i) begin : g_pair
               assign pair_clash[i*NUM_BANKS + j] =
                  ranges_meet(span_t'(BANK_BASE[i]), span_t'(BANK_SPAN),
                              span_t'(BANK_BASE[j]), span_t'(BANK_SPAN));
            end else begin : g_self
               assign pair_clash[i*NUM_BANKS + j] = 1'b0;
            end
         end
      end
   endgenerate

   assign data_clash = ranges_meet(span_t'(RAM_BASE), span_t'(RAM_LOCS),
                                   span_t'(IO_BASE),  span_t'(IO_SPAN));
   assign pio_clash  = ranges_meet(span_t'(PIO_BASE), span_t'(PIO_SPAN),
                                   span_t'(RAM_BASE), span_t'(RAM_LOCS))
                     | ranges_meet(span_t'(PIO_BASE), span_t'(PIO_SPAN),
                                   span_t'(IO_BASE),  span_t'(IO_SPAN));

   assign cfg_fault = (|pair_clash) | SPAN_BAD | data_clash | (pio_en & pio_clash);

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
   import memsel_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int BANK_KB  = 8,
   parameter int WIDE_BUS = 0,
   parameter logic [NUM_BANKS-1:0][31:0] BANK_BASE =
      {32'h0000_6000, 32'h0000_4000, 32'h0000_2000, 32'h0000_0000},
   parameter int unsigned BANK_SPAN = 32'h2000,
   parameter int unsigned RAM_BASE  = 32'h1000,
   parameter int unsigned IO_BASE   = 32'h5800,
   parameter int unsigned IO_SPAN   = 32'h100,
   parameter int unsigned PIO_BASE  = 32'h1_0000,
   parameter int unsigned PIO_SPAN  = 32'h100
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 addr_strobe,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 pio_en,
   output logic [NUM_BANKS-1:0] bank_sel,
   output logic                 ram_sel,
   output logic                 io_sel,
   output logic                 pio_sel,
   output logic                 cfg_err
);

   localparam int unsigned BANK_LOCS = (BANK_KB * 1024) >> WIDE_BUS;
   localparam int unsigned RAM_LOCS  = 2048 >> WIDE_BUS;
   localparam int unsigned CODE_LOCS = NUM_BANKS * BANK_LOCS;

   // elaboration-time parameter checks
   generate
      if (BANK_KB != 8 && BANK_KB != 16 && BANK_KB != 32) begin : g_bad_kb
         $error("memsel_decoder: BANK_KB must be 8, 16 or 32");
      end
      if (WIDE_BUS != 0 && WIDE_BUS != 1) begin : g_bad_bus
         $error("memsel_decoder: WIDE_BUS must be 0 or 1");
      end
      if (ADDR_W < $clog2(CODE_LOCS) || ADDR_W > 32) begin : g_bad_aw
         $error("memsel_decoder: ADDR_W cannot cover the code space");
      end
   endgenerate

   sel_t hits;
   sel_t win;
   sel_t sel_q;
   logic pio_raw;
   logic fault;
   logic err_q;

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_win
         memsel_window #(
            .ADDR_W (ADDR_W),
            .BASE   (BANK_BASE[k]),
            .SPAN   (BANK_SPAN)
         ) u_bank (
            .addr (addr),
            .hit  (hits.bank[k])
         );
      end
   endgenerate

   memsel_window #(.ADDR_W(ADDR_W), .BASE(RAM_BASE), .SPAN(RAM_LOCS)) u_ram (
      .addr (addr),
      .hit  (hits.ram)
   );

   memsel_window #(.ADDR_W(ADDR_W), .BASE(IO_BASE), .SPAN(IO_SPAN)) u_io (
      .addr (addr),
      .hit  (hits.io)
   );

   memsel_window #(.ADDR_W(ADDR_W), .BASE(PIO_BASE), .SPAN(PIO_SPAN)) u_pio (
      .addr (addr),
      .hit  (pio_raw)
   );

   assign hits.pio = pio_raw & pio_en;

   memsel_prio u_prio (
      .strobe (addr_strobe),
      .hits   (hits),
      .win    (win)
   );

   memsel_cfgchk #(
      .BANK_BASE (BANK_BASE),
      .BANK_SPAN (BANK_SPAN),
      .BANK_LOCS (BANK_LOCS),
      .RAM_BASE  (RAM_BASE),
      .RAM_LOCS  (RAM_LOCS),
      .IO_BASE   (IO_BASE),
      .IO_SPAN   (IO_SPAN),
      .PIO_BASE  (PIO_BASE),
      .PIO_SPAN  (PIO_SPAN)
   ) u_cfgchk (
      .pio_en    (pio_en),
      .cfg_fault (fault)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= '0;
         err_q <= 1'b0;
      end else begin
         sel_q <= win;
         err_q <= fault;
      end
   end

   assign bank_sel = sel_q.bank;
   assign ram_sel  = sel_q.ram;
   assign io_sel   = sel_q.io;
   assign pio_sel  = sel_q.pio;
   assign cfg_err  = err_q;

endmodule

// File: rtl/memsel_checker.sv
module memsel_checker
   import memsel_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 addr_strobe,
   input logic [ADDR_W-1:0]    addr,
   input logic                 pio_en,
   input logic [NUM_BANKS-1:0] bank_sel,
   input logic                 ram_sel,
   input logic                 io_sel,
   input logic                 pio_sel,
   input logic                 cfg_err
);

   logic [NUM_BANKS+2:0] all_sel;
   assign all_sel = {pio_sel, io_sel, ram_sel, bank_sel};

   AST_SINGLE_SEL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(all_sel)); // R7

   AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
      !addr_strobe |=> (all_sel == '0)); // R6

   AST_PIO_GATED: assert property (@(posedge clk) disable iff (rst)
      !pio_en |=> !pio_sel); // R5

   AST_HOLD_SEL: assert property (@(posedge clk) disable iff (rst)
      (addr_strobe && $past(addr_strobe) && addr == $past(addr)
       && pio_en == $past(pio_en) && !$past(rst)) |=> $stable(all_sel)); // R10

   AST_ERR_STEADY: assert property (@(posedge clk) disable iff (rst)
      (pio_en == $past(pio_en) && !$past(rst)) |=> $stable(cfg_err)); // R9

endmodule

bind memsel_decoder memsel_checker #(.ADDR_W(ADDR_W)) u_memsel_chk (.*);

// File: tb/memsel_decoder_test.sv
`timescale 1ns/1ps
module memsel_decoder_test;

   typedef struct packed {
      int unsigned      kb;
      int unsigned      wide;
      logic [3:0][31:0] base;
      int unsigned      span;
      int unsigned      ram;
      int unsigned      io;
      int unsigned      iospan;
      int unsigned      pio;
      int unsigned      piospan;
      int unsigned      amask;
   } cfg_t;

   localparam cfg_t C_UUT  = '{kb:8, wide:0, base:{32'h6000, 32'h4000, 32'h2000, 32'h0},
      span:32'h2000, ram:32'h1000, io:32'h5800, iospan:32'h100, pio:32'h10000,
      piospan:32'h100, amask:32'h1FFFF};
   localparam cfg_t C_WIDE = '{kb:16, wide:1, base:{32'h6000, 32'h4000, 32'h2000, 32'h0},
      span:32'h2000, ram:32'h3000, io:32'h7800, iospan:32'h80, pio:32'h8000,
      piospan:32'h80, amask:32'hFFFF};
   localparam cfg_t C_POV  = '{kb:8, wide:0, base:{32'h6000, 32'h4000, 32'h2000, 32'h0},
      span:32'h2000, ram:32'h1000, io:32'h5800, iospan:32'h100, pio:32'h1400,
      piospan:32'h100, amask:32'h1FFFF};
   localparam cfg_t C_BOV  = '{kb:8, wide:0, base:{32'h6000, 32'h4000, 32'h1000, 32'h0},
      span:32'h2000, ram:32'h1000, io:32'h5800, iospan:32'h100, pio:32'h10000,
      piospan:32'h100, amask:32'h1FFFF};
   localparam cfg_t C_BIG  = '{kb:8, wide:0, base:{32'hC000, 32'h8000, 32'h4000, 32'h0},
      span:32'h2001, ram:32'h1000, io:32'h5800, iospan:32'h100, pio:32'h10000,
      piospan:32'h100, amask:32'h1FFFF};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strobe_i = 1'b0;
   logic [16:0] addr_i = '0;
   logic        pio_i = 1'b0;
   logic [7:0]  o_uut, o_wide, o_pov, o_bov, o_big;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   memsel_decoder #(.ADDR_W(17), .BANK_KB(C_UUT.kb), .WIDE_BUS(C_UUT.wide),
      .BANK_BASE(C_UUT.base), .BANK_SPAN(C_UUT.span), .RAM_BASE(C_UUT.ram),
      .IO_BASE(C_UUT.io), .IO_SPAN(C_UUT.iospan), .PIO_BASE(C_UUT.pio),
      .PIO_SPAN(C_UUT.piospan)) uut (
      .clk(clk), .rst(rst), .addr_strobe(strobe_i), .addr(addr_i), .pio_en(pio_i),
      .bank_sel(o_uut[3:0]), .ram_sel(o_uut[4]), .io_sel(o_uut[5]),
      .pio_sel(o_uut[6]), .cfg_err(o_uut[7]));

   memsel_decoder #(.ADDR_W(16), .BANK_KB(C_WIDE.kb), .WIDE_BUS(C_WIDE.wide),
      .BANK_BASE(C_WIDE.base), .BANK_SPAN(C_WIDE.span), .RAM_BASE(C_WIDE.ram),
      .IO_BASE(C_WIDE.io), .IO_SPAN(C_WIDE.iospan), .PIO_BASE(C_WIDE.pio),
      .PIO_SPAN(C_WIDE.piospan)) u_wide (
      .clk(clk), .rst(rst), .addr_strobe(strobe_i), .addr(addr_i[15:0]), .pio_en(pio_i),
      .bank_sel(o_wide[3:0]), .ram_sel(o_wide[4]), .io_sel(o_wide[5]),
      .pio_sel(o_wide[6]), .cfg_err(o_wide[7]));

   memsel_decoder #(.ADDR_W(17), .BANK_KB(C_POV.kb), .WIDE_BUS(C_POV.wide),
      .BANK_BASE(C_POV.base), .BANK_SPAN(C_POV.span), .RAM_BASE(C_POV.ram),
      .IO_BASE(C_POV.io), .IO_SPAN(C_POV.iospan), .PIO_BASE(C_POV.pio),
      .PIO_SPAN(C_POV.piospan)) u_pov (
      .clk(clk), .rst(rst), .addr_strobe(strobe_i), .addr(addr_i), .pio_en(pio_i),
      .bank_sel(o_pov[3:0]), .ram_sel(o_pov[4]), .io_sel(o_pov[5]),
      .pio_sel(o_pov[6]), .cfg_err(o_pov[7]));

   memsel_decoder #(.ADDR_W(17), .BANK_KB(C_BOV.kb), .WIDE_BUS(C_BOV.wide),
      .BANK_BASE(C_BOV.base), .BANK_SPAN(C_BOV.span), .RAM_BASE(C_BOV.ram),
      .IO_BASE(C_BOV.io), .IO_SPAN(C_BOV.iospan), .PIO_BASE(C_BOV.pio),
      .PIO_SPAN(C_BOV.piospan)) u_bov (
      .clk(clk), .rst(rst), .addr_strobe(strobe_i), .addr(addr_i), .pio_en(pio_i),
      .bank_sel(o_bov[3:0]), .ram_sel(o_bov[4]), .io_sel(o_bov[5]),
      .pio_sel(o_bov[6]), .cfg_err(o_bov[7]));

   memsel_decoder #(.ADDR_W(17), .BANK_KB(C_BIG.kb), .WIDE_BUS(C_BIG.wide),
      .BANK_BASE(C_BIG.base), .BANK_SPAN(C_BIG.span), .RAM_BASE(C_BIG.ram),
      .IO_BASE(C_BIG.io), .IO_SPAN(C_BIG.iospan), .PIO_BASE(C_BIG.pio),
      .PIO_SPAN(C_BIG.piospan)) u_big (
      .clk(clk), .rst(rst), .addr_strobe(strobe_i), .addr(addr_i), .pio_en(pio_i),
      .bank_sel(o_big[3:0]), .ram_sel(o_big[4]), .io_sel(o_big[5]),
      .pio_sel(o_big[6]), .cfg_err(o_big[7]));

   function automatic bit in_win(longint a, longint b, longint s);
      return (s != 0) && (a >= b) && (a < b + s);
   endfunction

   function automatic bit meet(longint b1, longint s1, longint b2, longint s2);
      return (s1 != 0) && (s2 != 0) && (b1 < b2 + s2) && (b2 < b1 + s1);
   endfunction

   // expected {cfg_err, pio, io, ram, bank[3:0]}
   function automatic logic [7:0] expect_out(cfg_t c, int unsigned a_in, bit s, bit p);
      longint     a      = longint'(a_in & c.amask);
      longint     ramlen = longint'(2048 >> c.wide);
      longint     banklen = longint'((c.kb * 1024) >> c.wide);
      logic [6:0] sel    = '0;
      bit         err    = 1'b0;
      for (int i = 0; i < 4; i++)
         for (int j = i + 1; j < 4; j++)
            if (meet(c.base[i], c.span, c.base[j], c.span)) err = 1'b1;
      if (longint'(c.span) > banklen) err = 1'b1;
      if (meet(c.ram, ramlen, c.io, c.iospan)) err = 1'b1;
      if (p && (meet(c.pio, c.piospan, c.ram, ramlen) || meet(c.pio, c.piospan, c.io, c.iospan)))
         err = 1'b1;
      if (s) begin
         if (in_win(a, c.ram, ramlen))               sel = 7'b001_0000;
         else if (in_win(a, c.io, c.iospan))         sel = 7'b010_0000;
         else if (p && in_win(a, c.pio, c.piospan))  sel = 7'b100_0000;
         else begin
            for (int k = 3; k >= 0; k--)
               if (in_win(a, c.base[k], c.span)) sel = 7'(1 << k);
         end
      end
      return {err, sel};
   endfunction

   task automatic cmp(input string tag, input string who, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h strobe=%0b pio_en=%0b act=%b exp=%b",
                  tag, who, addr_i, strobe_i, pio_i, act, exp);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic apply(input int unsigned a, input bit s, input bit p, input string tag);
      addr_i   = a[16:0];
      strobe_i = s;
      pio_i    = p;
      @(negedge clk);
      cmp(tag, "uut",  o_uut,  expect_out(C_UUT,  a, s, p));
      cmp(tag, "wide", o_wide, expect_out(C_WIDE, a, s, p));
      cmp(tag, "pov",  o_pov,  expect_out(C_POV,  a, s, p));
      cmp(tag, "bov",  o_bov,  expect_out(C_BOV,  a, s, p));
      cmp(tag, "big",  o_big,  expect_out(C_BIG,  a, s, p));
   endtask

   task automatic check_reset(input string tag);
      cmp(tag, "uut",  o_uut,  8'h00);
      cmp(tag, "wide", o_wide, 8'h00);
      cmp(tag, "pov",  o_pov,  8'h00);
      cmp(tag, "bov",  o_bov,  8'h00);
      cmp(tag, "big",  o_big,  8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R10: reset holds everything low even with active inputs
      addr_i = 17'h1000; strobe_i = 1'b1; pio_i = 1'b1;
      repeat (3) @(negedge clk);
      check_reset("R10");
      rst = 1'b0;

      // R1 / R2: bank windows and their edges
      apply(32'h0000, 1, 0, "R1");
      apply(32'h0FFF, 1, 0, "R1");
      apply(32'h1FFF, 1, 0, "R1");
      apply(32'h2000, 1, 0, "R1");
      apply(32'h4000, 1, 0, "R1");
      apply(32'h7FFF, 1, 0, "R2");
      apply(32'h8000, 1, 0, "R2");
      apply(32'h1_7FFF, 1, 0, "R2");
      // R3: RAM window edges in both bus modes
      apply(32'h1000, 1, 0, "R3");
      apply(32'h17FF, 1, 0, "R3");
      apply(32'h1800, 1, 0, "R3");
      apply(32'h33FF, 1, 0, "R3");
      apply(32'h3400, 1, 0, "R3");
      // R4: I/O over code
      apply(32'h5800, 1, 0, "R4");
      apply(32'h58FF, 1, 0, "R4");
      apply(32'h5900, 1, 0, "R4");
      apply(32'h7800, 1, 1, "R4");
      // R5: peripheral window gating
      apply(32'h1_0000, 1, 1, "R5");
      apply(32'h1_0000, 1, 0, "R5");
      apply(32'h1_00FF, 1, 1, "R5");
      apply(32'h1450, 1, 0, "R5");
      apply(32'h1850, 1, 1, "R5");
      // R6: strobe low
      apply(32'h1000, 0, 1, "R6");
      apply(32'h2000, 0, 0, "R6");
      // R7: overlap priority
      apply(32'h1900, 1, 0, "R7");
      apply(32'h2500, 1, 0, "R7");
      apply(32'h2000, 1, 0, "R7");
      apply(32'h1450, 1, 1, "R7");
      // R8 / R9: configuration error flags
      apply(32'h0100, 1, 0, "R8");
      apply(32'h0100, 1, 1, "R9");
      apply(32'h0100, 1, 0, "R9");

      // R7: random sweep
      for (int n = 0; n < 3000; n++) begin
         int unsigned a;
         case ($urandom_range(0, 3))
            0: a = $urandom_range(32'h0F00, 32'h1900);
            1: a = $urandom_range(32'h5700, 32'h5A00);
            2: a = $urandom_range(32'hFF00, 32'h1_0200);
            default: a = $urandom_range(0, 32'h1_FFFF);
         endcase
         apply(a, ($urandom_range(0, 4) != 0), $urandom_range(0, 1) == 1, "R7");
      end

      // R10: synchronous reset in mid-run
      addr_i = 17'h1400; strobe_i = 1'b1; pio_i = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check_reset("R10");
      rst = 1'b0;
      apply(32'h1400, 1, 1, "R10");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule